// File: doc/BRIEF.md
# Hybrid Skewed Direction Predictor with Selective Update

This block predicts whether a conditional branch is taken. It holds four tables of 2-bit counters. One is a bimodal table, two are global tables meant to be reached through skewed hashes, and one is a chooser. The lookup port takes four ready-made table indices. It returns each table's prediction bit and the final direction. The chooser selects between the bimodal counter alone and a three-way majority vote of the bimodal and both global counters.

Each counter is stored as a direction bit and a hysteresis bit, kept in separate arrays. The second global table and the chooser have hysteresis arrays half as deep as their direction arrays. Two direction entries therefore share one hysteresis bit.

At commit, the caller presents the same four indices, the four component predictions it saved at lookup time, and the resolved outcome. The block then writes only the counters that the selective policy names. Hashing, history generation and multi-branch fetch belong to the caller.

Top module: `skew_hybrid_pred`

## Requirements
- R1: After reset every direction bit is 0 (not taken) and every hysteresis bit is 0 (weak), so every lookup returns 0 on all five prediction outputs.
- R2: `lkTaken` equals `lkBimPred` when `lkMetaPred` is 0, and equals the majority of `lkBimPred`, `lkG0Pred` and `lkG1Pred` when `lkMetaPred` is 1. All lookup outputs are combinational from the current array contents.
- R3: A correct update in which the three saved direction predictions are equal writes no counter.
- R4: Any other correct update strengthens the chooser when the bimodal and majority candidates differed. If the chooser was 0, it strengthens only the bimodal counter. If the chooser was 1, it strengthens each direction counter whose saved prediction equals the outcome.
- R5: On a misprediction with differing candidates, the chooser is trained toward the other candidate first. If that flips the chooser, the participating counters of the new choice are strengthened as in R4. Otherwise all three direction counters are trained toward the outcome.
- R6: On a misprediction with equal candidates, the chooser is untouched and all three direction counters are trained toward the outcome.
- R7: The counter rules are as follows. Strengthening sets hysteresis to 1 and leaves the direction bit alone. Training a counter whose saved prediction matches the target strengthens it. A wrong counter with hysteresis 1 only clears hysteresis. A wrong counter with hysteresis 0 has its direction bit set to the target.
- R8: A correct update never changes any direction bit.
- R9: For the second global table and the chooser, hysteresis is addressed by the index with its most significant bit dropped. Entries i and i + half-depth share one hysteresis bit.
- R10: When a lookup and an update hit the same entry in one cycle, the lookup returns the value held before the update. The new value is visible after the clock edge.
- R11: With `upValid` low, no array is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| lkBimIdx | input | BIM_IDX_W | Lookup index, bimodal table |
| lkG0Idx | input | G0_IDX_W | Lookup index, first global table |
| lkG1Idx | input | G1_IDX_W | Lookup index, second global table |
| lkMetaIdx | input | META_IDX_W | Lookup index, chooser |
| lkTaken | output | 1 | Final predicted direction |
| lkBimPred | output | 1 | Bimodal direction bit |
| lkG0Pred | output | 1 | First global direction bit |
| lkG1Pred | output | 1 | Second global direction bit |
| lkMetaPred | output | 1 | Chooser bit (1 selects majority) |
| upValid | input | 1 | Commit update strobe |
| upBimIdx | input | BIM_IDX_W | Update index, bimodal table |
| upG0Idx | input | G0_IDX_W | Update index, first global table |
| upG1Idx | input | G1_IDX_W | Update index, second global table |
| upMetaIdx | input | META_IDX_W | Update index, chooser |
| upBimPred | input | 1 | Saved bimodal prediction |
| upG0Pred | input | 1 | Saved first global prediction |
| upG1Pred | input | 1 | Saved second global prediction |
| upMetaPred | input | 1 | Saved chooser bit |
| upTaken | input | 1 | Resolved outcome |

## Verification
Some properties are checked on every cycle:
- no update strobe is raised when `upValid` is low;
- a correct update never asks for a direction-bit write;
- an agreeing correct update stays idle;
- a miss with agreeing candidates leaves the chooser alone;
- a chooser flip is followed only by strengthening.

Inside each table, the same checks confirm that direction bits move only on a flip request and that strengthening sets the hysteresis bit.

Other behaviour shows only across several updates, so the bench scenarios cover it. These include the two-step chooser recovery with re-selection, a strong counter giving up only its hysteresis, a write through one entry's shared hysteresis bit that changes how its partner trains, and the same-cycle read-before-write order.

// File: rtl/hp_pkg.sv
package hp_pkg;

  typedef enum logic [1:0] {
    CTR_KEEP   = 2'd0,
    CTR_STRONG = 2'd1,
    CTR_WEAKEN = 2'd2,
    CTR_FLIP   = 2'd3
  } ctrOp_e;

  typedef struct packed {
    ctrOp_e bimOp;
    ctrOp_e g0Op;
    ctrOp_e g1Op;
    ctrOp_e metaOp;
    logic   bimVal;
    logic   g0Val;
    logic   g1Val;
    logic   metaVal;
  } updStrobes_t;

endpackage

// File: rtl/hp_ctr_table.sv
module hp_ctr_table
  import hp_pkg::*;
#(
  parameter int IDX_W     = 5,
  parameter bit HALF_HYST = 1'b0
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [IDX_W-1:0] rdIdx,
  output logic             rdPred,
  input  logic [IDX_W-1:0] wrIdx,
  output logic             wrHyst,
  input  ctrOp_e           op,
  input  logic             val
);
  localparam int DEPTH  = 1 << IDX_W;
  localparam int HYST_W = HALF_HYST ? IDX_W - 1 : IDX_W;
  localparam int HDEPTH = 1 << HYST_W;

  logic [DEPTH-1:0]  predArr;
  logic [HDEPTH-1:0] hystArr;
  logic [HYST_W-1:0] hIdx;

  generate
    if (HALF_HYST) begin : g_shared
      assign hIdx = wrIdx[IDX_W-2:0];
    end else begin : g_full
      assign hIdx = wrIdx;
    end
  endgenerate

  assign rdPred = predArr[rdIdx];
  assign wrHyst = hystArr[hIdx];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      predArr <= '0;
      hystArr <= '0;
    end else begin
      case (op)
        CTR_STRONG: hystArr[hIdx] <= 1'b1;
        CTR_WEAKEN: hystArr[hIdx] <= 1'b0;
        CTR_FLIP:   predArr[wrIdx] <= val;
        default: ;
      endcase
    end
  end

  // R7 / R8: direction bits change only on a flip request
  p_pred_only_on_flip_r8: assert property (@(posedge clk) disable iff (!rstN)
    (op != CTR_FLIP) |=> $stable(predArr));

  p_flip_writes_target_r7: assert property (@(posedge clk) disable iff (!rstN)
    (op == CTR_FLIP) |=> (predArr[$past(wrIdx)] == $past(val)));

  p_strong_sets_hyst_r7: assert property (@(posedge clk) disable iff (!rstN)
    (op == CTR_STRONG) |=> hystArr[$past(hIdx)]);

endmodule

// File: rtl/hp_datapath.sv
module hp_datapath
  import hp_pkg::*;
#(
  parameter int BIM_IDX_W  = 4,
  parameter int G0_IDX_W   = 5,
  parameter int G1_IDX_W   = 5,
  parameter int META_IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BIM_IDX_W-1:0]  lkBimIdx,
  input  logic [G0_IDX_W-1:0]   lkG0Idx,
  input  logic [G1_IDX_W-1:0]   lkG1Idx,
  input  logic [META_IDX_W-1:0] lkMetaIdx,
  output logic                  lkTaken,
  output logic                  lkBimPred,
  output logic                  lkG0Pred,
  output logic                  lkG1Pred,
  output logic                  lkMetaPred,
  input  logic [BIM_IDX_W-1:0]  upBimIdx,
  input  logic [G0_IDX_W-1:0]   upG0Idx,
  input  logic [G1_IDX_W-1:0]   upG1Idx,
  input  logic [META_IDX_W-1:0] upMetaIdx,
  output logic                  bimHyst,
  output logic                  g0Hyst,
  output logic                  g1Hyst,
  output logic                  metaHyst,
  input  updStrobes_t           strobes
);
  logic voteMaj;

  hp_ctr_table #(.IDX_W(BIM_IDX_W), .HALF_HYST(1'b0)) u_bim (
    .clk(clk), .rstN(rstN), .rdIdx(lkBimIdx), .rdPred(lkBimPred),
    .wrIdx(upBimIdx), .wrHyst(bimHyst), .op(strobes.bimOp), .val(strobes.bimVal));

  hp_ctr_table #(.IDX_W(G0_IDX_W), .HALF_HYST(1'b0)) u_g0 (
    .clk(clk), .rstN(rstN), .rdIdx(lkG0Idx), .rdPred(lkG0Pred),
    .wrIdx(upG0Idx), .wrHyst(g0Hyst), .op(strobes.g0Op), .val(strobes.g0Val));

  hp_ctr_table #(.IDX_W(G1_IDX_W), .HALF_HYST(1'b1)) u_g1 (
    .clk(clk), .rstN(rstN), .rdIdx(lkG1Idx), .rdPred(lkG1Pred),
    .wrIdx(upG1Idx), .wrHyst(g1Hyst), .op(strobes.g1Op), .val(strobes.g1Val));

  hp_ctr_table #(.IDX_W(META_IDX_W), .HALF_HYST(1'b1)) u_meta (
    .clk(clk), .rstN(rstN), .rdIdx(lkMetaIdx), .rdPred(lkMetaPred),
    .wrIdx(upMetaIdx), .wrHyst(metaHyst), .op(strobes.metaOp), .val(strobes.metaVal));

  assign voteMaj = (lkBimPred & lkG0Pred) | (lkBimPred & lkG1Pred) | (lkG0Pred & lkG1Pred);
  assign lkTaken = lkMetaPred ? voteMaj : lkBimPred;

endmodule

// File: rtl/hp_control.sv
module hp_control
  import hp_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        upValid,
  input  logic        upBimPred,
  input  logic        upG0Pred,
  input  logic        upG1Pred,
  input  logic        upMetaPred,
  input  logic        upTaken,
  input  logic        bimHyst,
  input  logic        g0Hyst,
  input  logic        g1Hyst,
  input  logic        metaHyst,
  output updStrobes_t strobes
);
  logic majVote, differ, hit, agree, chooserFlips, trainAll;
  logic [2:0] strongSet;

  function automatic ctrOp_e trainOp(input logic pred, input logic hyst, input logic tgt);
    if (pred == tgt)  return CTR_STRONG;
    else if (hyst)    return CTR_WEAKEN;
    else              return CTR_FLIP;
  endfunction

  function automatic logic [2:0] participants(input logic useMaj, input logic b,
                                              input logic g0, input logic g1, input logic o);
    if (useMaj) return {b == o, g0 == o, g1 == o};
    else        return 3'b100;
  endfunction

  assign majVote      = (upBimPred & upG0Pred) | (upBimPred & upG1Pred) | (upG0Pred & upG1Pred);
  assign differ       = majVote ^ upBimPred;
  assign hit          = (upMetaPred ? majVote : upBimPred) == upTaken;
  assign agree        = (upBimPred == upG0Pred) && (upG0Pred == upG1Pred);
  assign chooserFlips = differ && !metaHyst;

  always_comb begin
    strobes.bimOp   = CTR_KEEP;
    strobes.g0Op    = CTR_KEEP;
    strobes.g1Op    = CTR_KEEP;
    strobes.metaOp  = CTR_KEEP;
    strobes.bimVal  = upTaken;
    strobes.g0Val   = upTaken;
    strobes.g1Val   = upTaken;
    strobes.metaVal = ~upMetaPred;
    strongSet       = 3'b000;
    trainAll        = 1'b0;
    if (upValid) begin
      if (hit) begin
        if (!agree) begin
          if (differ) strobes.metaOp = CTR_STRONG;
          strongSet = participants(upMetaPred, upBimPred, upG0Pred, upG1Pred, upTaken);
        end
      end else begin
        if (differ) strobes.metaOp = trainOp(upMetaPred, metaHyst, ~upMetaPred);
        if (chooserFlips)
          strongSet = participants(~upMetaPred, upBimPred, upG0Pred, upG1Pred, upTaken);
        else
          trainAll = 1'b1;
      end
    end
    if (trainAll) begin
      strobes.bimOp = trainOp(upBimPred, bimHyst, upTaken);
      strobes.g0Op  = trainOp(upG0Pred, g0Hyst, upTaken);
      strobes.g1Op  = trainOp(upG1Pred, g1Hyst, upTaken);
    end else begin
      if (strongSet[2]) strobes.bimOp = CTR_STRONG;
      if (strongSet[1]) strobes.g0Op  = CTR_STRONG;
      if (strongSet[0]) strobes.g1Op  = CTR_STRONG;
    end
  end

  p_idle_without_valid_r11: assert property (@(posedge clk) disable iff (!rstN)
    !upValid |-> (strobes.bimOp == CTR_KEEP && strobes.g0Op == CTR_KEEP &&
                  strobes.g1Op == CTR_KEEP && strobes.metaOp == CTR_KEEP));

  p_agree_hit_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && hit && agree) |-> (strobes.bimOp == CTR_KEEP && strobes.g0Op == CTR_KEEP &&
                                   strobes.g1Op == CTR_KEEP && strobes.metaOp == CTR_KEEP));

  p_no_flip_on_hit_r8: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && hit) |-> (strobes.bimOp != CTR_FLIP && strobes.g0Op != CTR_FLIP &&
                          strobes.g1Op != CTR_FLIP && strobes.metaOp != CTR_FLIP));

  p_meta_held_on_agree_miss_r6: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !hit && !differ) |-> (strobes.metaOp == CTR_KEEP));

  p_rechoose_strengthens_r5: assert property (@(posedge clk) disable iff (!rstN)
    (upValid && !hit && differ && !metaHyst) |->
      (strobes.metaOp == CTR_FLIP &&
       strobes.bimOp inside {CTR_KEEP, CTR_STRONG} &&
       strobes.g0Op inside {CTR_KEEP, CTR_STRONG} &&
       strobes.g1Op inside {CTR_KEEP, CTR_STRONG}));

endmodule

// File: rtl/skew_hybrid_pred.sv
module skew_hybrid_pred
  import hp_pkg::*;
#(
  parameter int BIM_IDX_W  = 4,
  parameter int G0_IDX_W   = 5,
  parameter int G1_IDX_W   = 5,
  parameter int META_IDX_W = 5
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [BIM_IDX_W-1:0]  lkBimIdx,
  input  logic [G0_IDX_W-1:0]   lkG0Idx,
  input  logic [G1_IDX_W-1:0]   lkG1Idx,
  input  logic [META_IDX_W-1:0] lkMetaIdx,
  output logic                  lkTaken,
  output logic                  lkBimPred,
  output logic                  lkG0Pred,
  output logic                  lkG1Pred,
  output logic                  lkMetaPred,
  input  logic                  upValid,
  input  logic [BIM_IDX_W-1:0]  upBimIdx,
  input  logic [G0_IDX_W-1:0]   upG0Idx,
  input  logic [G1_IDX_W-1:0]   upG1Idx,
  input  logic [META_IDX_W-1:0] upMetaIdx,
  input  logic                  upBimPred,
  input  logic                  upG0Pred,
  input  logic                  upG1Pred,
  input  logic                  upMetaPred,
  input  logic                  upTaken
);
  updStrobes_t strobes;
  logic bimHyst, g0Hyst, g1Hyst, metaHyst;

  hp_datapath #(
    .BIM_IDX_W(BIM_IDX_W), .G0_IDX_W(G0_IDX_W),
    .G1_IDX_W(G1_IDX_W), .META_IDX_W(META_IDX_W)
  ) u_dp (
    .clk(clk), .rstN(rstN),
    .lkBimIdx(lkBimIdx), .lkG0Idx(lkG0Idx), .lkG1Idx(lkG1Idx), .lkMetaIdx(lkMetaIdx),
    .lkTaken(lkTaken), .lkBimPred(lkBimPred), .lkG0Pred(lkG0Pred),
    .lkG1Pred(lkG1Pred), .lkMetaPred(lkMetaPred),
    .upBimIdx(upBimIdx), .upG0Idx(upG0Idx), .upG1Idx(upG1Idx), .upMetaIdx(upMetaIdx),
    .bimHyst(bimHyst), .g0Hyst(g0Hyst), .g1Hyst(g1Hyst), .metaHyst(metaHyst),
    .strobes(strobes));

  hp_control u_ctl (
    .clk(clk), .rstN(rstN), .upValid(upValid),
    .upBimPred(upBimPred), .upG0Pred(upG0Pred), .upG1Pred(upG1Pred),
    .upMetaPred(upMetaPred), .upTaken(upTaken),
    .bimHyst(bimHyst), .g0Hyst(g0Hyst), .g1Hyst(g1Hyst), .metaHyst(metaHyst),
    .strobes(strobes));

endmodule

// File: tb/sim_skew_hybrid_pred.sv
`timescale 1ns/1ps
module sim_skew_hybrid_pred;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic [3:0] lkBimIdx = '0, upBimIdx = '0;
  logic [4:0] lkG0Idx = '0, lkG1Idx = '0, lkMetaIdx = '0;
  logic [4:0] upG0Idx = '0, upG1Idx = '0, upMetaIdx = '0;
  logic lkTaken, lkBimPred, lkG0Pred, lkG1Pred, lkMetaPred;
  logic upValid = 1'b0, upBimPred = 1'b0, upG0Pred = 1'b0, upG1Pred = 1'b0;
  logic upMetaPred = 1'b0, upTaken = 1'b0;

  int checks = 0;
  int failures = 0;
  bit finished = 0;

  // bench model of the arrays
  logic [15:0] mBimP = '0, mBimH = '0;
  logic [31:0] mG0P = '0, mG0H = '0, mG1P = '0, mMtP = '0;
  logic [15:0] mG1H = '0, mMtH = '0;

  always #2.5 clk = ~clk;

  skew_hybrid_pred u0 (
    .clk(clk), .rstN(rstN),
    .lkBimIdx(lkBimIdx), .lkG0Idx(lkG0Idx), .lkG1Idx(lkG1Idx), .lkMetaIdx(lkMetaIdx),
    .lkTaken(lkTaken), .lkBimPred(lkBimPred), .lkG0Pred(lkG0Pred),
    .lkG1Pred(lkG1Pred), .lkMetaPred(lkMetaPred),
    .upValid(upValid), .upBimIdx(upBimIdx), .upG0Idx(upG0Idx),
    .upG1Idx(upG1Idx), .upMetaIdx(upMetaIdx),
    .upBimPred(upBimPred), .upG0Pred(upG0Pred), .upG1Pred(upG1Pred),
    .upMetaPred(upMetaPred), .upTaken(upTaken));

  task automatic chk(input string tag, input logic got, input logic exp);
    checks++;
    if (got !== exp) begin
      failures++;
      $display("FAIL %s got=%0b exp=%0b", tag, got, exp);
    end
  endtask

  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

  function automatic logic [1:0] nextCtr(input logic p, input logic h, input logic s,
                                         input logic t, input logic tgt);
    if (s) return {p, 1'b1};
    if (t) begin
      if (p == tgt) return {p, 1'b1};
      if (h)        return {p, 1'b0};
      return {tgt, 1'b0};
    end
    return {p, h};
  endfunction

  function automatic logic [2:0] partic(input logic sel, input logic bp, input logic g0p,
                                        input logic g1p, input logic o);
    return sel ? {bp == o, g0p == o, g1p == o} : 3'b100;
  endfunction

  task automatic cmpModel(input string tag);
    logic eb, e0, e1, em;
    eb = mBimP[lkBimIdx]; e0 = mG0P[lkG0Idx]; e1 = mG1P[lkG1Idx]; em = mMtP[lkMetaIdx];
    chk({tag, " bim"}, lkBimPred, eb);
    chk({tag, " g0"}, lkG0Pred, e0);
    chk({tag, " g1"}, lkG1Pred, e1);
    chk({tag, " meta"}, lkMetaPred, em);
    chk({tag, " taken"}, lkTaken, em ? maj3(eb, e0, e1) : eb);
  endtask

  task automatic modelUpd(input logic [4:0] b, input logic [4:0] g0, input logic [4:0] g1,
                          input logic [4:0] m, input logic bp, input logic g0p,
                          input logic g1p, input logic mp, input logic o);
    logic mj, df, ov, hitm, agr, sM, tM, tAll;
    logic [2:0] sSet;
    logic [1:0] r;
    mj = maj3(bp, g0p, g1p); df = mj ^ bp; ov = mp ? mj : bp; hitm = (ov == o);
    agr = (bp == g0p) && (g0p == g1p);
    sM = 0; tM = 0; tAll = 0; sSet = 3'b000;
    if (hitm) begin
      if (!agr) begin sM = df; sSet = partic(mp, bp, g0p, g1p, o); end
    end else begin
      tM = df;
      if (df && !mMtH[m[3:0]]) sSet = partic(~mp, bp, g0p, g1p, o);
      else tAll = 1;
    end
    r = nextCtr(bp,  mBimH[b[3:0]], sSet[2], tAll, o); mBimP[b[3:0]] = r[1]; mBimH[b[3:0]] = r[0];
    r = nextCtr(g0p, mG0H[g0],      sSet[1], tAll, o); mG0P[g0] = r[1];      mG0H[g0] = r[0];
    r = nextCtr(g1p, mG1H[g1[3:0]], sSet[0], tAll, o); mG1P[g1] = r[1];      mG1H[g1[3:0]] = r[0];
    r = nextCtr(mp,  mMtH[m[3:0]],  sM, tM, ~mp);      mMtP[m] = r[1];       mMtH[m[3:0]] = r[0];
  endtask

  // one lookup plus same-cycle update on the same entries
  task automatic step(input logic [4:0] b, input logic [4:0] g0, input logic [4:0] g1,
                      input logic [4:0] m, input logic o, input logic vld);
    logic bp, g0p, g1p, mp, ov;
    @(negedge clk);
    lkBimIdx = b[3:0]; lkG0Idx = g0; lkG1Idx = g1; lkMetaIdx = m;
    upBimIdx = b[3:0]; upG0Idx = g0; upG1Idx = g1; upMetaIdx = m;
    upValid = 1'b0;
    #1;
    cmpModel("R2 lookup");
    bp = lkBimPred; g0p = lkG0Pred; g1p = lkG1Pred; mp = lkMetaPred; ov = lkTaken;
    upBimPred = bp; upG0Pred = g0p; upG1Pred = g1p; upMetaPred = mp; upTaken = o;
    upValid = vld;
    #1;
    chk("R10 pre-edge bim", lkBimPred, bp);
    @(posedge clk);
    if (vld) modelUpd(b, g0, g1, m, bp, g0p, g1p, mp, o);
    #1;
    upValid = 1'b0;
    if (!vld) begin
      cmpModel("R11 ignored");
    end else begin
      cmpModel("R10 post-edge");
      if (ov == o) begin
        chk("R8 bim kept", lkBimPred, bp);
        chk("R8 g0 kept", lkG0Pred, g0p);
        chk("R8 g1 kept", lkG1Pred, g1p);
        chk("R8 meta kept", lkMetaPred, mp);
      end
    end
  endtask

  initial begin
    #(5.0 * 150000);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'd1234));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;

    // R1: reset state
    for (int i = 0; i < 16; i++) begin
      @(negedge clk);
      lkBimIdx = i[3:0]; lkG0Idx = 5'(i + 16); lkG1Idx = 5'(i); lkMetaIdx = 5'(i + 16);
      #1;
      chk("R1 bim", lkBimPred, 1'b0);
      chk("R1 g0", lkG0Pred, 1'b0);
      chk("R1 g1", lkG1Pred, 1'b0);
      chk("R1 meta", lkMetaPred, 1'b0);
      chk("R1 taken", lkTaken, 1'b0);
    end

    // R6 / R3: agreeing miss trains all, agreeing hit leaves weak counters weak
    step(5'd1, 5'd1, 5'd1, 5'd1, 1'b1, 1'b1);
    chk("R6 bim flipped", lkBimPred, 1'b1);
    chk("R6 g0 flipped", lkG0Pred, 1'b1);
    chk("R6 g1 flipped", lkG1Pred, 1'b1);
    chk("R6 meta held", lkMetaPred, 1'b0);
    step(5'd1, 5'd1, 5'd1, 5'd1, 1'b1, 1'b1);
    step(5'd1, 5'd1, 5'd1, 5'd1, 1'b0, 1'b1);
    chk("R3 bim still weak", lkBimPred, 1'b0);
    chk("R3 g0 still weak", lkG0Pred, 1'b0);
    chk("R3 g1 still weak", lkG1Pred, 1'b0);

    // R4 / R7 / R5: chooser strengthen, strong counter keeps direction, re-choice
    step(5'd2, 5'd2, 5'd2, 5'd2, 1'b1, 1'b1);
    step(5'd2, 5'd3, 5'd3, 5'd3, 1'b1, 1'b1);
    chk("R2 bimodal chosen", lkTaken, 1'b1);
    step(5'd2, 5'd3, 5'd3, 5'd3, 1'b0, 1'b1);
    chk("R7 strong bim keeps direction", lkBimPred, 1'b1);
    chk("R4 strong meta only weakened", lkMetaPred, 1'b0);
    step(5'd2, 5'd3, 5'd3, 5'd3, 1'b0, 1'b1);
    chk("R5 meta flipped", lkMetaPred, 1'b1);
    chk("R5 bim not trained after rechoice", lkBimPred, 1'b1);
    chk("R2 majority chosen", lkTaken, 1'b0);

    // R9: shared hysteresis in second global table (entries 4 and 20)
    step(5'd4, 5'd4, 5'd4, 5'd4, 1'b1, 1'b1);
    step(5'd5, 5'd4, 5'd4, 5'd5, 1'b1, 1'b1);
    chk("R5 majority now chosen", lkMetaPred, 1'b1);
    step(5'd6, 5'd6, 5'd20, 5'd6, 1'b1, 1'b1);
    chk("R9 g1 partner only cleared shared hysteresis", lkG1Pred, 1'b0);
    chk("R9 bim flipped alongside", lkBimPred, 1'b1);

    // R11: no write without valid
    step(5'd7, 5'd7, 5'd7, 5'd7, 1'b1, 1'b0);
    chk("R11 bim", lkBimPred, 1'b0);
    chk("R11 g0", lkG0Pred, 1'b0);

    // random phase against the model
    for (int n = 0; n < 600; n++) begin
      logic [4:0] rb, r0, r1, rm;
      logic ro, rv;
      rb = 5'($urandom % 16); r0 = 5'($urandom % 32);
      r1 = 5'($urandom % 32); rm = 5'($urandom % 32);
      ro = ($urandom % 4) != 0;
      rv = ($urandom % 8) != 0;
      step(rb, r0, r1, rm, ro, rv);
    end

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule